// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a clocked internal bus and an external asynchronous static RAM with 17 address bits and a shared 8-bit data bus. A requester pulses `req` together with a direction, an address and (for stores) a byte. The controller then runs one access on the RAM pins through a four-state sequence: `ST_IDLE`, `ST_SETUP`, `ST_STROBE`, `ST_HOLD`. On the pin side it drives a pair of chip selects of opposite sense, an active-low output strobe, an active-low write strobe, and a split data path (`mem_dq_out`, `mem_dq_oe`, `mem_dq_in`) that the chip pad ring joins into one bidirectional bus.

Every RAM timing limit is a parameter in nanoseconds. Each one is turned at elaboration into a whole number of clock periods, rounded up, and a down-counter holds the state machine in each state for that many cycles. The transitions are: `ST_IDLE` to `ST_SETUP` when a request is accepted; `ST_SETUP` to `ST_STROBE` when the setup count expires; `ST_STROBE` to `ST_HOLD` when the strobe count expires, which also captures read data and raises `ready`; `ST_HOLD` to `ST_IDLE` when the hold count expires. Stores keep the output strobe high, so the RAM never drives the bus while the controller does.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and in every idle cycle, `mem_ce_n`=1, `mem_ce`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `ready`=0.
- R2: For each accepted request, `mem_ce_n`=0 and `mem_ce`=1 from the cycle after acceptance through the last strobe cycle, and both return to their inactive levels together.
- R3: On a store, `mem_we_n` is low for exactly WT consecutive cycles, starting after S selected cycles, only while the RAM is selected and `mem_oe_n` is high.
- R4: `mem_dq_oe` is 1 exactly during the write strobe and the write hold cycles, with `mem_dq_out` equal to the requested byte. It is never 1 while `mem_oe_n` is low or while the RAM can drive the bus.
- R5: `mem_addr` equals the requested address from the cycle after acceptance until the last hold cycle, and does not change while the RAM is selected.
- R6: On a load, `mem_oe_n` is low for exactly RT consecutive cycles after S selected cycles, and `mem_we_n` stays high for the whole access.
- R7: `ready` is a one-cycle pulse in the first cycle after the last strobe cycle. After a load, `rdata` equals the byte presented on `mem_dq_in` in the last strobe cycle.
- R8: The counts are S = max(1, ceil(ADDR_SETUP_NS/CLK_NS)); WT = max(1, ceil(WR_PULSE_NS), ceil(WR_DATA_SETUP_NS), ceil(ADDR_TO_WEND_NS) - S); RT = max(1, ceil(OE_ACCESS_NS), ceil(RD_ACCESS_NS) - S); WH = max(1, ceil(HOLD_NS), ceil(WR_CYCLE_NS) - S - WT); RH = max(1, ceil(HOLD_NS), ceil(RD_TURNOFF_NS), ceil(RD_CYCLE_NS) - S - RT). Each ceil is in clock periods.
- R9: After the strobe, the RAM is deselected with both strobes high for WH (store) or RH (load) cycles, then the block is idle for one cycle. With `req` held high, the next access is selected S+T+H+1 cycles after the previous one was.
- R10: A request that arrives while an access is in progress is ignored. The running access keeps its address and data, and no second access follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled only when idle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to store |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last loaded byte |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data received from the RAM bus |

## Verification
A counter loaded with the wrong count, or a state that is left at the wrong edge, shows up at once as a strobe that is one cycle too long or too short. It can also show up as a `ready` pulse in the wrong cycle, and both are seen on the access where the fault happens. A state decode that mixes up direction would show `mem_dq_oe` high during a load strobe, which the bench flags in that same cycle as bus contention against its RAM model. A lost address or data register appears as a wrong byte written into the model, which is caught when that location is read back later in the sweep.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } sram_st_e;

    // Nanoseconds to clock periods, rounded up.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_dwell_cnt.sv
module sram_dwell_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              drive,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (load)    wdata_q <= load_data;
            if (capture) rdata_q <= dq_in;
        end
    end

    assign dq_out = wdata_q;
    assign dq_oe  = drive;
    assign rdata  = rdata_q;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W           = 17,
    parameter int DATA_W           = 8,
    parameter int CLK_NS           = 20,
    parameter int ADDR_SETUP_NS    = 0,
    parameter int WR_PULSE_NS      = 12,
    parameter int WR_DATA_SETUP_NS = 7,
    parameter int ADDR_TO_WEND_NS  = 12,
    parameter int WR_CYCLE_NS      = 15,
    parameter int RD_ACCESS_NS     = 15,
    parameter int OE_ACCESS_NS     = 7,
    parameter int RD_CYCLE_NS      = 15,
    parameter int HOLD_NS          = 0,
    parameter int RD_TURNOFF_NS    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Dwell times in clock periods (R8).
    localparam int S_CYC  = imax(1, ns_to_cyc(ADDR_SETUP_NS, CLK_NS));
    localparam int WT_CYC = imax(imax(1, ns_to_cyc(WR_PULSE_NS, CLK_NS)),
                                 imax(ns_to_cyc(WR_DATA_SETUP_NS, CLK_NS),
                                      ns_to_cyc(ADDR_TO_WEND_NS, CLK_NS) - S_CYC));
    localparam int RT_CYC = imax(imax(1, ns_to_cyc(OE_ACCESS_NS, CLK_NS)),
                                 ns_to_cyc(RD_ACCESS_NS, CLK_NS) - S_CYC);
    localparam int WH_CYC = imax(imax(1, ns_to_cyc(HOLD_NS, CLK_NS)),
                                 ns_to_cyc(WR_CYCLE_NS, CLK_NS) - S_CYC - WT_CYC);
    localparam int RH_CYC = imax(imax(imax(1, ns_to_cyc(HOLD_NS, CLK_NS)),
                                      ns_to_cyc(RD_TURNOFF_NS, CLK_NS)),
                                 ns_to_cyc(RD_CYCLE_NS, CLK_NS) - S_CYC - RT_CYC);
    localparam int MAX_CYC = imax(imax(S_CYC, WT_CYC), imax(imax(RT_CYC, WH_CYC), RH_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    sram_st_e          state_q, state_d;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic              ready_q, ready_d;
    logic              accept, capture;
    logic              cnt_load, cnt_zero;
    logic [CNT_W-1:0]  cnt_val;
    logic              sel, drv_en;

    // Next state and counter reload.
    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        capture  = 1'b0;
        ready_d  = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept   = 1'b1;
                    state_d  = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(S_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d  = ST_STROBE;
                    cnt_load = 1'b1;
                    cnt_val  = wr_q ? CNT_W'(WT_CYC - 1) : CNT_W'(RT_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (cnt_zero) begin
                    state_d  = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = wr_q ? CNT_W'(WH_CYC - 1) : CNT_W'(RH_CYC - 1);
                    ready_d  = 1'b1;
                    capture  = !wr_q;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and request latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ready_q <= ready_d;
            if (accept) begin
                wr_q   <= req_we;
                addr_q <= req_addr;
            end
        end
    end

    // Pin levels decoded from the current state.
    always_comb begin
        sel      = (state_q == ST_SETUP) || (state_q == ST_STROBE);
        mem_ce_n = !sel;
        mem_ce   = sel;
        mem_oe_n = !((state_q == ST_STROBE) && !wr_q);
        mem_we_n = !((state_q == ST_STROBE) && wr_q);
        drv_en   = wr_q && ((state_q == ST_STROBE) || (state_q == ST_HOLD));
    end

    assign mem_addr = addr_q;
    assign ready    = ready_q;

    sram_dwell_cnt #(.W(CNT_W)) i_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_dq_port #(.DATA_W(DATA_W)) i_dq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (req_wdata),
        .drive     (drv_en),
        .capture   (capture),
        .dq_in     (mem_dq_in),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe),
        .rdata     (rdata)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n
                                  && !mem_dq_oe && !ready));

    p_we_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce && mem_oe_n));

    p_no_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_rd_we_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && mem_ce));

    p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(mem_addr) && $stable(mem_dq_out)));

endmodule

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    localparam int CLK_NS = 20;
    localparam int A_SU = 25, W_PW = 45, W_DS = 30, A_WE = 70, W_CY = 150;
    localparam int R_AA = 90, R_OE = 70, R_CY = 110, H_NS = 10, R_TO = 35;

    function automatic int up(input int ns);
        return (ns + CLK_NS - 1) / CLK_NS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int S  = mx(1, up(A_SU));
    localparam int WT = mx(mx(1, up(W_PW)), mx(up(W_DS), up(A_WE) - S));
    localparam int RT = mx(mx(1, up(R_OE)), up(R_AA) - S);
    localparam int WH = mx(mx(1, up(H_NS)), up(W_CY) - S - WT);
    localparam int RH = mx(mx(mx(1, up(H_NS)), up(R_TO)), up(R_CY) - S - RT);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, req_we;
    logic [16:0] req_addr;
    logic [7:0]  req_wdata;
    logic        ready;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sram_async_ctrl #(
        .CLK_NS(CLK_NS), .ADDR_SETUP_NS(A_SU), .WR_PULSE_NS(W_PW),
        .WR_DATA_SETUP_NS(W_DS), .ADDR_TO_WEND_NS(A_WE), .WR_CYCLE_NS(W_CY),
        .RD_ACCESS_NS(R_AA), .OE_ACCESS_NS(R_OE), .RD_CYCLE_NS(R_CY),
        .HOLD_NS(H_NS), .RD_TURNOFF_NS(R_TO)
    ) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .rdata(rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Small RAM model indexed by the low address bits.
    logic [7:0] ram     [64];
    logic [7:0] exp_mem [64];
    wire ram_sel = !mem_ce_n && mem_ce;
    wire ram_drv = ram_sel && !mem_oe_n && mem_we_n;
    assign mem_dq_in = ram_drv ? ram[mem_addr[5:0]] : 8'h00;

    always @(negedge clk) begin
        if (ram_sel && !mem_we_n)
            ram[mem_addr[5:0]] <= mem_dq_oe ? mem_dq_out : 8'hEE;
        if (rst_n && mem_dq_oe && ram_drv) begin
            checks++;
            fails++;
            $display("FAIL R4 bus contention act=1 exp=0");
        end
    end

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", r, act, exp);
        end
    endtask

    task automatic do_op(input bit we, input logic [16:0] a, input logic [7:0] d,
                         input bit inject);
        int t, h, n_set, n_stb;
        t = we ? WT : RT;
        h = we ? WH : RH;
        n_set = 0;
        n_stb = 0;
        @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        for (int k = 1; k <= S + t + h + 1; k++) begin
            @(negedge clk);
            if (k == 1) req = 1'b0;
            if (inject && k == 2) begin
                req = 1'b1; req_we = 1'b1; req_addr = a ^ 17'h0002A; req_wdata = ~d;
            end
            if (inject && k == 3) req = 1'b0;
            if (ram_sel && mem_oe_n && mem_we_n && k <= S) n_set++;
            if (!mem_oe_n || !mem_we_n) n_stb++;
            chk(k > S + t ? "R9 deselect" : "R2 select",
                {30'd0, !mem_ce_n, mem_ce}, (k <= S + t) ? 3 : 0);
            chk("R6 oe_n", mem_oe_n, !(!we && k > S && k <= S + t));
            chk("R3 we_n", mem_we_n, !(we && k > S && k <= S + t));
            chk("R4 dq_oe", mem_dq_oe, we && k > S && k <= S + t + h);
            if (we && k > S && k <= S + t + h) chk("R4 wdata", mem_dq_out, d);
            if (k <= S + t + h) chk("R5 addr", mem_addr, a);
            if (k == S + t + h + 1) chk("R1 idle ready", ready, 0);
            else chk("R7 ready", ready, k == S + t + 1);
            if (!we && k == S + t + 1) chk("R7 rdata", rdata, exp_mem[a[5:0]]);
        end
        chk("R8 setup cycles", n_set, S);
        chk("R8 strobe cycles", n_stb, t);
        if (we) exp_mem[a[5:0]] = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            ram[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset select", {30'd0, !mem_ce_n, mem_ce}, 0);
        chk("R1 reset strobes", {30'd0, mem_oe_n, mem_we_n}, 3);
        chk("R1 reset dq_oe", mem_dq_oe, 0);
        chk("R1 reset ready", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle strobes", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 7);

        // Store sweep over varied addresses and data, then load back.
        for (int i = 0; i < 32; i++)
            do_op(1'b1, {11'(i * 97 + 5), 6'(i * 5 + 3)}, 8'(i * 37 + 11), 1'b0);
        for (int i = 31; i >= 0; i--)
            do_op(1'b0, {11'(i * 13), 6'(i * 5 + 3)}, 8'h00, 1'b0);
        // Never-written location loads as zero.
        do_op(1'b0, 17'h1FFC2, 8'h00, 1'b0);

        // R9: request held high, spacing between selected phases.
        begin
            int k;
            bit seen_off;
            k = 0;
            seen_off = 1'b0;
            @(negedge clk);
            req = 1'b1; req_we = 1'b0; req_addr = 17'h00003;
            for (int j = 1; j < 40; j++) begin
                @(negedge clk);
                if (mem_ce_n) seen_off = 1'b1;
                if (seen_off && !mem_ce_n && k == 0) k = j;
            end
            req = 1'b0;
            chk("R9 back-to-back spacing", k, S + RT + RH + 2);
            repeat (S + RT + RH + 4) @(negedge clk);
        end

        // R10: request during a busy access is ignored.
        do_op(1'b1, 17'h0A401, 8'h5C, 1'b1);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R10 no second access", mem_ce_n, 1);
        end
        do_op(1'b0, 17'h0A401 ^ 17'h0002A, 8'h00, 1'b0);
        do_op(1'b0, 17'h0A401, 8'h00, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule